// File: doc/BRIEF.md
# Transmit/Receive Byte Queue Pair with Zero-Based Fill Levels

This block sits between a serial bus controller's register interface and its bus engine. It holds two first-in first-out queues. The transmit queue carries 10-bit entries, an 8-bit data byte plus two control bits that the bus engine decodes. The receive queue carries plain bytes. Both queues hold 16 entries by default.

Each queue reports its fill level as a read-only value encoded as count minus one. An empty queue reads 0, and the matching empty flag is what tells that apart from one stored entry. A programmable receive threshold, also encoded as count minus one, raises a receive-level event. The transmit side raises events when it drains completely and when it drops to half-empty. A transmit flush control holds the transmit queue empty while it is asserted.

All four data paths are valid/ready streams. A transfer takes place on a rising clock edge when both valid and ready are high. `tx_in_ready` is low while the transmit queue is full or flushed. `rx_in_ready` is low while the receive queue is full. The `*_out_valid` outputs are low while their queue is empty, and also during a flush for the transmit queue. A source may hold valid high without a transfer, and the data is then simply not taken. A sink may raise ready at any time without effect when valid is low.

Top module: `byte_queue_pair`

## Requirements
- R1: Each queue accepts exactly 16 entries. After that its input ready is low until an entry leaves.
- R2: Entries leave each queue in the order they were accepted, with all bits intact (10 bits transmit, 8 bits receive). The output data is valid whenever out_valid is high.
- R3: `tx_level` reads the stored entry count minus one, and reads 0 when the queue is empty. It updates in the cycle after the accepting edge.
- R4: `rx_level` reads the stored byte count minus one, and reads 0 when the queue is empty. It updates in the cycle after the accepting edge.
- R5: `status` bit 4 is set when the transmit queue holds 16 entries, bit 5 when the receive queue holds 16, bit 6 when the receive queue is empty, and bit 7 when the transmit queue is empty. All other bits read 0, so after reset `status` reads 0xC0.
- R6: While `tx_flush` is high, `tx_in_ready` and `tx_out_valid` are low. From the edge after it is first sampled high, the transmit queue is empty (level 0, bit 7 set).
- R7: A receive pop (`rx_out_ready` with `rx_out_valid`) removes exactly one byte. With the receive queue empty, `rx_out_valid` is low and raising `rx_out_ready` leaves level and status unchanged.
- R8: A transmit write offered while the queue is full is not taken. The stored entries and the level are unchanged.
- R9: `rx_thresh` resets to 15 and loads `rx_thresh_din` on a clock edge where `rx_thresh_we` is high. `rx_level_evt` is a one-cycle pulse in the first cycle in which the receive count exceeds the threshold, that is, N+1 bytes held for threshold N. This includes the case where a threshold write causes the crossing.
- R10: `tx_empty_evt` is a one-cycle pulse in the first cycle in which the transmit queue becomes empty after holding entries. There is no pulse at reset.
- R11: `tx_half_evt` is a one-cycle pulse in the first cycle in which the transmit queue holds 8 or fewer entries after holding more than 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | Register side offers a transmit entry |
| tx_in_ready | output | 1 | Transmit queue can take an entry |
| tx_in_data | input | 10 | Transmit entry (byte plus two control bits) |
| tx_out_valid | output | 1 | Transmit head entry available to the bus engine |
| tx_out_ready | input | 1 | Bus engine takes the head entry |
| tx_out_data | output | 10 | Transmit head entry |
| tx_flush | input | 1 | Hold the transmit queue empty |
| rx_in_valid | input | 1 | Bus engine offers a received byte |
| rx_in_ready | output | 1 | Receive queue can take a byte |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive head byte available |
| rx_out_ready | input | 1 | Register side reads (pops) the head byte |
| rx_out_data | output | 8 | Receive head byte |
| rx_thresh_we | input | 1 | Load the receive threshold |
| rx_thresh_din | input | 4 | New receive threshold (count minus one) |
| rx_thresh | output | 4 | Current receive threshold |
| tx_level | output | 4 | Transmit entries minus one, 0 when empty |
| rx_level | output | 4 | Receive bytes minus one, 0 when empty |
| status | output | 8 | Queue flags (bits 4..7) |
| rx_level_evt | output | 1 | Receive count crossed above the threshold |
| tx_empty_evt | output | 1 | Transmit queue just became empty |
| tx_half_evt | output | 1 | Transmit queue just dropped to half or less |

## Verification
The readies and valids react to `tx_flush` and to the queue counts within the same cycle. The levels, the status flags and the head data change in the cycle after the accepting edge, because each passes through one count or pointer register. The three event pulses are high in that same following cycle and drop one cycle later. The bench mirrors this with a behavioural model that advances at each rising edge on the inputs as driven. It compares every output at the falling edge, where each result of the preceding edge is due. Stimulus changes only just after that comparison.

// File: rtl/bq_pkg.sv
package bq_pkg;
  // Status flag positions decoded by the register interface.
  localparam int unsigned ST_TX_FULL  = 4;
  localparam int unsigned ST_RX_FULL  = 5;
  localparam int unsigned ST_RX_EMPTY = 6;
  localparam int unsigned ST_TX_EMPTY = 7;
  localparam int unsigned ST_WIDTH    = 8;

  typedef struct packed {
    logic rx_level;
    logic tx_empty;
    logic tx_half;
  } bq_cond_t;
endpackage

// File: rtl/bq_fifo.sv
module bq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WIDTH-1:0]           in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WIDTH-1:0]           out_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH)-1:0]   level
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != FULL) && !flush;
  assign out_valid = (count != '0) && !flush;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];
  assign level     = (count == '0) ? '0 : AW'(count - 1'b1);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL) |-> !in_ready); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R6
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == '0) && !in_valid) |=> (count == '0)); // R7
  AST_POP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> (count == $past(count) - 1'b1)); // R7
endmodule

// File: rtl/bq_edge_event.sv
module bq_edge_event #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic pulse
);
  logic cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= INIT;
    else        cond_q <= cond;
  end

  assign pulse = cond && !cond_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R9
endmodule

// File: rtl/byte_queue_pair.sv
module byte_queue_pair #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TX_WIDTH = 10,
  parameter int unsigned RX_WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_in_valid,
  output logic                       tx_in_ready,
  input  logic [TX_WIDTH-1:0]        tx_in_data,
  output logic                       tx_out_valid,
  input  logic                       tx_out_ready,
  output logic [TX_WIDTH-1:0]        tx_out_data,
  input  logic                       tx_flush,
  input  logic                       rx_in_valid,
  output logic                       rx_in_ready,
  input  logic [RX_WIDTH-1:0]        rx_in_data,
  output logic                       rx_out_valid,
  input  logic                       rx_out_ready,
  output logic [RX_WIDTH-1:0]        rx_out_data,
  input  logic                       rx_thresh_we,
  input  logic [$clog2(DEPTH)-1:0]   rx_thresh_din,
  output logic [$clog2(DEPTH)-1:0]   rx_thresh,
  output logic [$clog2(DEPTH)-1:0]   tx_level,
  output logic [$clog2(DEPTH)-1:0]   rx_level,
  output logic [7:0]                 status,
  output logic                       rx_level_evt,
  output logic                       tx_empty_evt,
  output logic                       tx_half_evt
);
  import bq_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0] tx_count, rx_count;
  bq_cond_t      cond, pulse;

  bq_fifo #(.WIDTH(TX_WIDTH), .DEPTH(DEPTH)) u_tx (
    .clk, .rst_n, .flush(tx_flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_count), .level(tx_level)
  );

  bq_fifo #(.WIDTH(RX_WIDTH), .DEPTH(DEPTH)) u_rx (
    .clk, .rst_n, .flush(1'b0),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_count), .level(rx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rx_thresh <= AW'(DEPTH - 1);
    else if (rx_thresh_we) rx_thresh <= rx_thresh_din;
  end

  always_comb begin
    cond.rx_level = rx_count > CW'(rx_thresh);
    cond.tx_empty = (tx_count == '0);
    cond.tx_half  = (tx_count <= HALF);
  end

  // Event conditions true at reset start with a high history bit.
  localparam bq_cond_t INIT_HIST = '{rx_level: 1'b0, tx_empty: 1'b1, tx_half: 1'b1};

  for (genvar g = 0; g < 3; g++) begin : g_evt
    bq_edge_event #(.INIT(INIT_HIST[g])) u_evt (
      .clk, .rst_n, .cond(cond[g]), .pulse(pulse[g])
    );
  end

  assign rx_level_evt = pulse.rx_level;
  assign tx_empty_evt = pulse.tx_empty;
  assign tx_half_evt  = pulse.tx_half;

  always_comb begin
    status              = '0;
    status[ST_TX_FULL]  = (tx_count == FULL);
    status[ST_RX_FULL]  = (rx_count == FULL);
    status[ST_RX_EMPTY] = (rx_count == '0);
    status[ST_TX_EMPTY] = (tx_count == '0);
  end

  AST_FLUSH_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> (!tx_in_ready && !tx_out_valid)); // R6
  AST_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_thresh_we |=> $stable(rx_thresh)); // R9
  AST_EMPTY_EVT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |-> status[ST_TX_EMPTY]); // R10
  AST_HALF_EVT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half_evt |-> !status[ST_TX_FULL]); // R11
  AST_RX_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_RX_EMPTY] |-> !rx_out_valid); // R7
endmodule

// File: tb/tb_byte_queue_pair.sv
`timescale 1ns/1ps
module tb_byte_queue_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_in_valid = 0, tx_out_ready = 0, tx_flush = 0;
  logic [9:0] tx_in_data = '0;
  logic       rx_in_valid = 0, rx_out_ready = 0, rx_thresh_we = 0;
  logic [7:0] rx_in_data = '0;
  logic [3:0] rx_thresh_din = '0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [9:0] tx_out_data;
  logic [7:0] rx_out_data;
  logic [3:0] rx_thresh, tx_level, rx_level;
  logic [7:0] status;
  logic       rx_level_evt, tx_empty_evt, tx_half_evt;

  always #5 clk = ~clk;

  byte_queue_pair dut (
    .clk, .rst_n, .tx_in_valid, .tx_in_ready, .tx_in_data, .tx_out_valid,
    .tx_out_ready, .tx_out_data, .tx_flush, .rx_in_valid, .rx_in_ready,
    .rx_in_data, .rx_out_valid, .rx_out_ready, .rx_out_data, .rx_thresh_we,
    .rx_thresh_din, .rx_thresh, .tx_level, .rx_level, .status,
    .rx_level_evt, .tx_empty_evt, .tx_half_evt
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference model.
  logic [9:0] txq[$];
  logic [7:0] rxq[$];
  int thr = 15;
  bit h_rx = 0, h_te = 1, h_th = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); thr = 15; h_rx = 0; h_te = 1; h_th = 1;
    end else begin
      bit tpush, tpop, rpush, rpop;
      h_rx = (rxq.size() > thr);
      h_te = (txq.size() == 0);
      h_th = (txq.size() <= 8);
      tpush = tx_in_valid && txq.size() < 16 && !tx_flush;
      tpop  = tx_out_ready && txq.size() > 0 && !tx_flush;
      rpush = rx_in_valid && rxq.size() < 16;
      rpop  = rx_out_ready && rxq.size() > 0;
      if (tx_flush) txq.delete();
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_in_data);
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_in_data);
      if (rx_thresh_we) thr = int'(rx_thresh_din);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare everything away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int nt, nr;
      logic [7:0] st;
      nt = txq.size();
      nr = rxq.size();
      st = '0;
      st[4] = (nt == 16); st[5] = (nr == 16); st[6] = (nr == 0); st[7] = (nt == 0);
      chk("R1", "tx_in_ready", tx_in_ready, (nt < 16) && !tx_flush);
      chk("R1", "rx_in_ready", rx_in_ready, nr < 16);
      chk(tx_flush ? "R6" : "R2", "tx_out_valid", tx_out_valid, (nt > 0) && !tx_flush);
      chk("R7", "rx_out_valid", rx_out_valid, nr > 0);
      if (nt > 0) chk("R2", "tx_out_data", tx_out_data, txq[0]);
      if (nr > 0) chk("R2", "rx_out_data", rx_out_data, rxq[0]);
      chk("R3", "tx_level", tx_level, (nt == 0) ? 0 : nt - 1);
      chk("R4", "rx_level", rx_level, (nr == 0) ? 0 : nr - 1);
      chk("R5", "status", status, st);
      chk("R9", "rx_thresh", rx_thresh, thr);
      chk("R9", "rx_level_evt", rx_level_evt, (nr > thr) && !h_rx);
      chk("R10", "tx_empty_evt", tx_empty_evt, (nt == 0) && !h_te);
      chk("R11", "tx_half_evt", tx_half_evt, (nt <= 8) && !h_th);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R5", "status after reset", status, 8'hC0);
    chk("R9", "threshold after reset", rx_thresh, 15);
    chk("R10", "no empty pulse at reset", tx_empty_evt, 0);

    // Fill transmit queue past capacity (R1, R8).
    tx_in_valid = 1;
    for (int i = 0; i < 18; i++) begin
      tx_in_data = 10'(10'h300 + i);
      cyc(1);
    end
    tx_in_valid = 0;
    chk("R8", "full tx refuses", tx_in_ready, 0);
    chk("R3", "full tx level", tx_level, 15);

    // Drain, crossing half and empty (R10, R11).
    tx_out_ready = 1;
    cyc(18);
    tx_out_ready = 0;
    chk("R3", "drained tx level", tx_level, 0);

    // Receive fill then pop past empty (R4, R7).
    rx_in_valid = 1;
    for (int i = 0; i < 17; i++) begin
      rx_in_data = 8'(i * 7 + 1);
      cyc(1);
    end
    rx_in_valid = 0;
    chk("R5", "rx full flag", status[5], 1);
    rx_out_ready = 1;
    cyc(19);
    rx_out_ready = 0;
    chk("R7", "rx empty after over-read", rx_level, 0);

    // Threshold crossings, including by threshold write (R9).
    rx_thresh_we = 1; rx_thresh_din = 4'd3; cyc(1); rx_thresh_we = 0;
    rx_in_valid = 1;
    for (int i = 0; i < 5; i++) begin
      rx_in_data = 8'(8'hA0 + i);
      cyc(1);
    end
    rx_in_valid = 0;
    rx_thresh_we = 1; rx_thresh_din = 4'd15; cyc(1);
    rx_thresh_din = 4'd1; cyc(1); rx_thresh_we = 0;
    cyc(2);
    rx_out_ready = 1; cyc(6); rx_out_ready = 0;

    // Flush with writes offered (R6).
    tx_in_valid = 1;
    for (int i = 0; i < 6; i++) begin
      tx_in_data = 10'(10'h0F0 + i);
      cyc(1);
    end
    tx_flush = 1; tx_out_ready = 1;
    cyc(3);
    tx_flush = 0; tx_out_ready = 0;
    cyc(2);
    tx_in_valid = 0;
    chk("R6", "tx level after flush", tx_level, 1);
    tx_out_ready = 1; cyc(4); tx_out_ready = 0;

    // Mixed random traffic.
    for (int i = 0; i < 4000; i++) begin
      tx_in_valid   = 1'($urandom % 3 != 0);
      tx_in_data    = 10'($urandom);
      tx_out_ready  = 1'($urandom % 2);
      tx_flush      = ($urandom % 60 == 0);
      rx_in_valid   = 1'($urandom % 2);
      rx_in_data    = 8'($urandom);
      rx_out_ready  = 1'($urandom % 3 == 0);
      rx_thresh_we  = ($urandom % 40 == 0);
      rx_thresh_din = 4'($urandom);
      cyc(1);
    end
    tx_in_valid = 0; tx_out_ready = 0; tx_flush = 0;
    rx_in_valid = 0; rx_out_ready = 0; rx_thresh_we = 0;
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule